// File: doc/BRIEF.md
# PMIC Register-Access Bus Bridge

This block sits on a host's memory-mapped bus and gives software access to the 16-bit registers of a remote power-management device. The access runs over a three-wire synchronous serial link: an active-low select, a data-out line and a data-in line, moving one bit per clock. A host store that lands anywhere in the 4 KB slave window (offsets 0x8000 to 0x8FFF) becomes an address/data pair. That pair goes into an eight-entry write queue, and the queued pairs leave on the link strictly in arrival order.

Reads are commands. The host stores a remote address into the read-command register. The bridge waits until every queued write has left. It then runs a read frame on its own and posts the result word. That word holds the returned data next to the address the frame actually carried, so software can compare it with what it asked for. A busy flag in the same word tells software when the result is ready. A queue status word reports the full and empty states, plus a sticky flag for stores that were lost to a full queue.

Top module: `pmic_bridge`

## Requirements
- R1: A host store to an offset whose bits 15:12 equal 0x8 is queued as {offset[11:0], data[15:0]} and sent as exactly one write frame. Frames leave in store order. A store to any other offset (for example 0x0040 or 0x9000) produces no frame.
- R2: A frame keeps `link_csn` low for exactly 29 clocks. Bit 0 is the direction (1 read, 0 write), then 12 address bits MSB first, then 16 data bits MSB first. Between frames `link_csn` is high for at least one clock. With the link idle, a write frame starts on the clock after the store that fills the empty queue.
- R3: A store to offset 0x28 while not busy starts a remote read with no further host action. Bit 31 of the result word at offset 0x2C reads 1 from the clock after that store until the read frame has completed.
- R4: After completion the result word has bit 31 = 0, bits 15:0 = the data returned by the remote device, and bits 30:16 = the low 12 bits of the requested address, zero-extended.
- R5: A store to offset 0x28 while busy is ignored. The pending read keeps its first address and only one read frame is sent.
- R6: A read frame starts only when the write queue is empty and no frame is in flight, so every write queued before the read command reaches the remote device first.
- R7: The status word at offset 0x30 has bit 10 = queue empty, bit 11 = queue full (8 entries held), bit 12 = overflow; all other bits are 0.
- R8: A window store that arrives while the queue is full is dropped and sets the overflow bit, which then stays set until reset.
- R9: After reset `link_csn` is high, offset 0x30 reads 0x0000_0400 and offset 0x2C reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus side and the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Host store strobe, one clock per store |
| bus_addr | input | 16 | Host byte offset for stores and loads |
| bus_wdata | input | 16 | Host store data |
| bus_rdata | output | 32 | Register contents at `bus_addr` (combinational) |
| link_csn | output | 1 | Active-low frame select |
| link_mosi | output | 1 | Serial data to the remote device |
| link_miso | input | 1 | Serial data from the remote device |

## Verification
The bench builds the bridge with its default 12-bit remote address and an 8-entry queue. At that depth, a burst of nine back-to-back stores fills the queue while the first frame is still on the wire. A tenth store then reaches the drop-and-flag path, and a read-back shows the dropped store was lost. The 12-bit address field lets a read command carrying set upper bits show that only the low 12 bits are echoed. A behavioural remote device holding 4096 registers makes read-after-write and write-before-read ordering directly observable.

// File: rtl/pmb_pkg.sv
// Shared constants for the PMIC register-access bridge.
// Assumes a 16-bit host offset space and 16-bit remote registers.
package pmb_pkg;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned ECHO_W    = 15;
    localparam logic [15:0] OFS_RDCMD = 16'h0028;
    localparam logic [15:0] OFS_RDRES = 16'h002C;
    localparam logic [15:0] OFS_QSTAT = 16'h0030;
    localparam logic [3:0]  WIN_PAGE  = 4'h8;
    localparam int unsigned BIT_BUSY  = 31;
    localparam int unsigned BIT_FULL  = 11;
    localparam int unsigned BIT_EMPTY = 10;
    localparam int unsigned BIT_OVF   = 12;
endpackage

// File: rtl/pmb_fifo.sv
// Write queue: a circular buffer of DEPTH entries of W bits.
// Assumes push while full is dropped here; the parent records the loss.
module pmb_fifo #(
    parameter int unsigned W     = 28,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CNT_MAX);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rp];

    // Write the accepted entry into storage.
    always_ff @(posedge clk) begin
        if (do_push) store[wp] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_MAX) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_MAX) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(wp)));
endmodule

// File: rtl/pmb_shifter.sv
// Serial frame engine: sends {dir, addr, data} MSB first, one bit per clock,
// under an active-low select, and shifts the input line in alongside.
// Assumes the remote device drives read data during the last DATA_W clocks.
module pmb_shifter #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic [ADDR_W-1:0] sent_addr,
    output logic              csn,
    output logic              mosi,
    input  logic              miso
);
    localparam int unsigned FW    = 1 + ADDR_W + DATA_W;
    localparam int unsigned CNT_W = $clog2(FW);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(FW - 1);
    localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W);

    logic [FW-1:0]     shreg;
    logic [CNT_W-1:0]  cnt;
    logic              act_q, done_q;
    logic [ADDR_W-1:0] addr_q;

    assign active    = act_q;
    assign done      = done_q;
    assign csn       = !act_q;
    assign mosi      = act_q & shreg[FW-1];
    assign rx_data   = shreg[DATA_W-1:0];
    assign sent_addr = addr_q;

    // Load a frame, shift it out bit by bit, and capture the address on the wire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            done_q <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
            addr_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!act_q) begin
                if (start) begin
                    act_q <= 1'b1;
                    cnt   <= '0;
                    shreg <= {start_rd, start_addr, start_data};
                end
            end else begin
                shreg <= {shreg[FW-2:0], miso};
                cnt   <= cnt + 1'b1;
                if (cnt != '0 && cnt <= ADDR_END)
                    addr_q <= {addr_q[ADDR_W-2:0], shreg[FW-1]};
                if (cnt == LAST) begin
                    act_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && cnt == LAST) |=> (csn && done_q));
    // R2
    csn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> csn);
endmodule

// File: rtl/pmic_bridge.sv
// Bridge top: decodes host stores, queues window writes, holds the read
// command state and the result word, and arbitrates the serial engine.
// Assumes single-cycle host stores and combinational host loads.
module pmic_bridge #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        link_csn,
    output logic        link_mosi,
    input  logic        link_miso
);
    import pmb_pkg::*;

    localparam int unsigned ENTRY_W = ADDR_W + WORD_W;

    logic               win_hit, cmd_hit;
    logic [ENTRY_W-1:0] f_dout;
    logic               f_full, f_empty;
    logic               launch_rd, launch_wr, sh_active, sh_done;
    logic [WORD_W-1:0]  sh_rx;
    logic [ADDR_W-1:0]  sh_sent, start_addr;
    logic [WORD_W-1:0]  start_data;
    logic               busy_q, pend_q, frame_rd_q, ovf_q;
    logic [ADDR_W-1:0]  tgt_q, echo_q;
    logic [WORD_W-1:0]  rval_q;
    logic               unused_bits;

    assign unused_bits = ^bus_wdata[WORD_W-1:ADDR_W];

    // Decode host stores into window writes and read commands.
    assign win_hit = bus_we && (bus_addr[15:12] == WIN_PAGE);
    assign cmd_hit = bus_we && (bus_addr == OFS_RDCMD);

    // Pick the next frame: a read waits for the queue to drain.
    assign launch_rd  = pend_q && f_empty && !sh_active;
    assign launch_wr  = !f_empty && !sh_active;
    assign start_addr = launch_rd ? tgt_q : f_dout[ENTRY_W-1:WORD_W];
    assign start_data = launch_rd ? '0 : f_dout[WORD_W-1:0];

    pmb_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (win_hit),
        .pop   (launch_wr),
        .din   ({bus_addr[ADDR_W-1:0], bus_wdata}),
        .dout  (f_dout),
        .full  (f_full),
        .empty (f_empty)
    );

    pmb_shifter #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (launch_rd || launch_wr),
        .start_rd   (launch_rd),
        .start_addr (start_addr),
        .start_data (start_data),
        .active     (sh_active),
        .done       (sh_done),
        .rx_data    (sh_rx),
        .sent_addr  (sh_sent),
        .csn        (link_csn),
        .mosi       (link_mosi),
        .miso       (link_miso)
    );

    // Track read command, in-flight read and posted result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            pend_q     <= 1'b0;
            frame_rd_q <= 1'b0;
            tgt_q      <= '0;
            echo_q     <= '0;
            rval_q     <= '0;
        end else begin
            if (cmd_hit && !busy_q) begin
                busy_q <= 1'b1;
                pend_q <= 1'b1;
                tgt_q  <= bus_wdata[ADDR_W-1:0];
            end
            if (launch_rd || launch_wr) frame_rd_q <= launch_rd;
            if (launch_rd) pend_q <= 1'b0;
            if (sh_done && frame_rd_q) begin
                busy_q <= 1'b0;
                rval_q <= sh_rx;
                echo_q <= sh_sent;
            end
        end
    end

    // Record stores lost to a full queue until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf_q <= 1'b0;
        else if (win_hit && f_full) ovf_q <= 1'b1;
    end

    // Return the addressed host register.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_RDRES) begin
            bus_rdata[BIT_BUSY]          = busy_q;
            bus_rdata[WORD_W +: ECHO_W]  = ECHO_W'(echo_q);
            bus_rdata[WORD_W-1:0]        = rval_q;
        end else if (bus_addr == OFS_QSTAT) begin
            bus_rdata[BIT_FULL]  = f_full;
            bus_rdata[BIT_EMPTY] = f_empty;
            bus_rdata[BIT_OVF]   = ovf_q;
        end
    end

    // R3
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !busy_q) |=> busy_q);
    // R5
    cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && busy_q) |=> $stable(tgt_q));
    // R6
    read_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(link_csn) && frame_rd_q) |-> $past(f_empty));
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
endmodule

// File: tb/pmic_bridge_tb.sv
// Scoreboard bench: host stores push expected frames, a behavioural remote
// device pops and compares them as frames complete on the link.
module pmic_bridge_tb;
    import pmb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        link_csn, link_mosi;
    logic        link_miso = 1'b0;

    always #10 clk = ~clk;

    pmic_bridge #(.ADDR_W(12), .FIFO_DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_csn(link_csn),
        .link_mosi(link_mosi), .link_miso(link_miso)
    );

    int checks = 0;
    int fails = 0;
    int frames_wr = 0;
    int frames_rd = 0;
    logic [27:0] exp_q[$];
    logic [15:0] slave_mem [4096];
    logic [15:0] ref_mem [4096];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural remote device and scoreboard monitor.
    int          bitn = 0;
    logic [28:0] frm = '0;
    bit          is_rd = 0;
    logic [15:0] rdw = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            bitn = 0;
            link_miso = 1'b0;
        end else if (link_csn) begin
            if (bitn != 0) check("R2 frame length", 32'(bitn), 32'd29);
            bitn = 0;
            link_miso = 1'b0;
        end else begin
            frm = {frm[27:0], link_mosi};
            if (bitn == 12) begin
                is_rd = frm[12];
                if (is_rd) begin
                    rdw = slave_mem[frm[11:0]];
                    frames_rd++;
                    check("R6 queue drained before read frame", 32'(exp_q.size()), 32'd0);
                end
            end
            if (is_rd && bitn >= 13 && bitn <= 28) link_miso = rdw[28-bitn];
            if (bitn == 28 && !is_rd) begin
                frames_wr++;
                if (exp_q.size() == 0)
                    check("R1 unexpected write frame", {4'h0, frm[27:0]}, 32'hFFFF_FFFF);
                else
                    check("R1 write frame order", {4'h0, frm[27:0]}, {4'h0, exp_q.pop_front()});
                slave_mem[frm[27:16]] = frm[15:0];
            end
            bitn++;
        end
    end

    task automatic hw(input logic [15:0] a, input logic [15:0] d, input bit queued);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        if (queued && a[15:12] == 4'h8) begin
            exp_q.push_back({a[11:0], d});
            ref_mem[a[11:0]] = d;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [15:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_done(output logic [31:0] v);
        int n = 0;
        peek(OFS_RDRES, v);
        while (v[31] && n < 500) begin
            @(negedge clk);
            peek(OFS_RDRES, v);
            n++;
        end
        check("R3 busy clears on completion", {31'b0, v[31]}, 32'd0);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        peek(OFS_QSTAT, v);
        while (!(v[10] && link_csn) && n < 2000) begin
            @(negedge clk);
            peek(OFS_QSTAT, v);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_read(input logic [15:0] cmd);
        logic [31:0] v;
        hw(OFS_RDCMD, cmd, 0);
        idle();
        peek(OFS_RDRES, v);
        check("R3 busy set after command", {31'b0, v[31]}, 32'd1);
        wait_done(v);
        check("R4 read data", {16'h0, v[15:0]}, {16'h0, ref_mem[cmd[11:0]]});
        check("R4 echoed address", {17'h0, v[30:16]}, {20'h0, cmd[11:0]});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int rd_before, wr_before;
        for (int i = 0; i < 4096; i++) begin
            slave_mem[i] = '0;
            ref_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 select idle high", {31'b0, link_csn}, 32'd1);
        peek(OFS_QSTAT, v);
        check("R9 status after reset", v, 32'h0000_0400);
        peek(OFS_RDRES, v);
        check("R9 result after reset", v, 32'h0);

        // R1 window writes, window edges
        hw(16'h8010, 16'h1234, 1);
        hw(16'h8FFF, 16'hABCD, 1);
        hw(16'h8000, 16'h5A5A, 1);
        idle();
        wait_idle();
        check("R1 three write frames", 32'(frames_wr), 32'd3);

        // R3 R4 read-back with echo
        do_read(16'h0010);
        do_read(16'h0FFF);
        do_read(16'h0000);
        do_read(16'hF010);

        // R1 stores outside the window make no frame
        wr_before = frames_wr;
        hw(16'h0040, 16'h7777, 0);
        hw(16'h9000, 16'h8888, 0);
        idle();
        repeat (40) @(negedge clk);
        check("R1 no frame outside window", 32'(frames_wr), 32'(wr_before));

        // R6 read right behind queued writes
        hw(16'h8123, 16'hBEEF, 1);
        hw(16'h8124, 16'h1111, 1);
        do_read(16'h0123);

        // R5 second command while busy is ignored
        hw(16'h8200, 16'h2222, 1);
        hw(16'h8300, 16'h3333, 1);
        idle();
        wait_idle();
        rd_before = frames_rd;
        hw(OFS_RDCMD, 16'h0200, 0);
        hw(OFS_RDCMD, 16'h0300, 0);
        idle();
        wait_done(v);
        check("R5 echo keeps first address", {17'h0, v[30:16]}, 32'h0000_0200);
        check("R5 data of first address", {16'h0, v[15:0]}, 32'h0000_2222);
        repeat (40) @(negedge clk);
        check("R5 one read frame", 32'(frames_rd - rd_before), 32'd1);

        // R7 R8 fill the queue, then overflow
        for (int i = 0; i < 9; i++) hw(16'h8400 + 16'(i), 16'h4000 + 16'(i), 1);
        idle();
        peek(OFS_QSTAT, v);
        check("R7 full with eight held", v, 32'h0000_0800);
        hw(16'h8500, 16'hDEAD, 0);
        idle();
        peek(OFS_QSTAT, v);
        check("R8 overflow flagged", v, 32'h0000_1800);
        wait_idle();
        peek(OFS_QSTAT, v);
        check("R8 overflow sticky after drain", v, 32'h0000_1400);
        do_read(16'h0500);
        do_read(16'h0408);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule